// File: doc/BRIEF.md
# Packed Halfword Add-Subtract Unit

This block is a SIMD adder for a 32-bit datapath. It splits each operand into two signed 16-bit lanes and applies one of four lane operations: parallel add, parallel subtract, and two exchange forms. In the exchange forms, the low lane of one operand meets the high lane of the other. Each halfword operation has two forms:

- **Wrapping form.** It truncates each lane and reports, for each lane, whether the full-precision result was non-negative.
- **Saturating form.** It clamps each lane to the signed 16-bit range and reports nothing.

A byte mode treats the operands as four unsigned 8-bit lanes. It adds them with wrap-around and reports the carry out of each byte.

An operation is issued by holding `op_en` high for one clock edge. The packed result, the 4-bit flag vector and a one-cycle flag write strobe appear on the registered outputs after that edge. A surrounding core copies the flags into its own status register when the strobe is high.

Top module: `pk_addsub`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `flags` is 0 and `flag_we` is 0.
- R2: With `op_sel`=0 (parallel add) and `byte_sel`=0, the low lane is N[15:0]+M[15:0] and the high lane is N[31:16]+M[31:16]. The low lane is packed into result[15:0] and the high lane into result[31:16].
- R3: With `op_sel`=1 (parallel subtract), the low lane is N.lo−M.lo and the high lane is N.hi−M.hi.
- R4: With `op_sel`=2 (exchange, add low), the low lane is N.lo+M.hi and the high lane is N.hi−M.lo.
- R5: With `op_sel`=3 (exchange, subtract low), the low lane is N.lo−M.hi and the high lane is N.hi+M.lo.
- R6: In wrapping halfword mode (`sat_sel`=0), each lane is truncated to 16 bits. flags[1:0] are both 1 when the 17-bit low-lane result is ≥ 0 and both 0 otherwise. flags[3:2] follow the high lane in the same way.
- R7: With `sat_sel`=1 and `byte_sel`=0, each lane result is clamped to the range −32768..+32767 before packing.
- R8: A saturating operation leaves `flags` unchanged, and `flag_we` stays 0 after it.
- R9: With `byte_sel`=1, `op_sel` and `sat_sel` are ignored. Byte k of the result is (N byte k + M byte k) mod 256. flags[k] is the carry out of that byte sum.
- R10: Outputs change only at a clock edge where `op_en` is 1. `flag_we` is 1 for exactly the cycle after each wrapping or byte operation.
- R11: Every flag-updating operation writes every flag bit, clearing bits that an earlier operation had set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Issue an operation at this edge |
| n_opd | input | 32 | Operand N |
| m_opd | input | 32 | Operand M |
| op_sel | input | 2 | Lane operation: 0 add, 1 subtract, 2 exchange add-low, 3 exchange subtract-low |
| sat_sel | input | 1 | 1 selects the saturating form |
| byte_sel | input | 1 | 1 selects the unsigned four-byte add |
| result | output | 32 | Packed lane result |
| flags | output | 4 | Greater-or-equal or carry flags |
| flag_we | output | 1 | Flags were written by the last operation |

## Verification
The bench adds 0x7FFF to 1 in wrapping mode. The flag must read non-negative even though the truncated lane looks negative, so a design that takes the sign from the 16-bit result fails here. It drives lanes beyond both saturation limits; swapped or missing clamp bounds show up as wrapped values. The exchange modes use four distinct lane values, so a design that crosses the wrong lanes or applies the wrong sign produces a visibly wrong half. After all flags have been set, an operation that clears them catches a design that only sets flags. A saturating operation and a byte operation with a junk `op_sel` and `sat_sel` then confirm that those inputs are ignored where the requirements say they are.

// File: rtl/pk_addsub_pkg.sv
package pk_addsub_pkg;
  typedef enum logic [1:0] {
    HOP_ADD = 2'd0,
    HOP_SUB = 2'd1,
    HOP_XAS = 2'd2,   // lo = n.lo + m.hi, hi = n.hi - m.lo
    HOP_XSA = 2'd3    // lo = n.lo - m.hi, hi = n.hi + m.lo
  } hop_e;
endpackage

// File: rtl/pk_addsub_lane.sv
module pk_addsub_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sat,
  output logic [W-1:0] res,
  output logic         nonneg
);
  localparam logic signed [W:0] LMAX = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] LMIN = {2'b11, {(W-1){1'b0}}};

  logic signed [W:0] a_x, b_x, full;

  always_comb begin
    a_x  = {a[W-1], a};
    b_x  = {b[W-1], b};
    full = sub ? (a_x - b_x) : (a_x + b_x);
    if (sat && (full > LMAX))      res = LMAX[W-1:0];
    else if (sat && (full < LMIN)) res = LMIN[W-1:0];
    else                           res = full[W-1:0];
    nonneg = ~full[W];
  end
endmodule

// File: rtl/pk_addsub_bytes.sv
module pk_addsub_bytes #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   sum,
  output logic [DATA_W/8-1:0] carry
);
  localparam int NB = DATA_W / 8;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [8:0] s9;
    assign s9           = {1'b0, a[8*k +: 8]} + {1'b0, b[8*k +: 8]};
    assign sum[8*k +: 8] = s9[7:0];
    assign carry[k]      = s9[8];
  end
endmodule

// File: rtl/pk_addsub.sv
module pk_addsub #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_en,
  input  logic [DATA_W-1:0]   n_opd,
  input  logic [DATA_W-1:0]   m_opd,
  input  logic [1:0]          op_sel,
  input  logic                sat_sel,
  input  logic                byte_sel,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/8-1:0] flags,
  output logic                flag_we
);
  import pk_addsub_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam int FLAG_W = DATA_W / 8;
  localparam int FPH    = FLAG_W / 2;

  hop_e              op;
  logic [HALF_W-1:0] n_lo, n_hi, m_lo, m_hi;
  logic [HALF_W-1:0] lo_b, hi_b, lo_res, hi_res;
  logic              lo_sub, hi_sub, lo_nn, hi_nn;
  logic [DATA_W-1:0] byte_sum;
  logic [FLAG_W-1:0] byte_cy;

  logic [DATA_W-1:0] result_nxt;
  logic [FLAG_W-1:0] flags_nxt;
  logic              upd_flags;

  // Lane routing: straight ops pair like halves, exchange ops cross them.
  always_comb begin
    op   = hop_e'(op_sel);
    n_lo = n_opd[HALF_W-1:0];
    n_hi = n_opd[DATA_W-1:HALF_W];
    m_lo = m_opd[HALF_W-1:0];
    m_hi = m_opd[DATA_W-1:HALF_W];
    lo_b = ((op == HOP_ADD) || (op == HOP_SUB)) ? m_lo : m_hi;
    hi_b = ((op == HOP_ADD) || (op == HOP_SUB)) ? m_hi : m_lo;
    lo_sub = (op == HOP_SUB) || (op == HOP_XSA);
    hi_sub = (op == HOP_SUB) || (op == HOP_XAS);
  end

  pk_addsub_lane #(.W(HALF_W)) i_lane_lo (
    .a(n_lo), .b(lo_b), .sub(lo_sub), .sat(sat_sel), .res(lo_res), .nonneg(lo_nn)
  );

  pk_addsub_lane #(.W(HALF_W)) i_lane_hi (
    .a(n_hi), .b(hi_b), .sub(hi_sub), .sat(sat_sel), .res(hi_res), .nonneg(hi_nn)
  );

  pk_addsub_bytes #(.DATA_W(DATA_W)) i_bytes (
    .a(n_opd), .b(m_opd), .sum(byte_sum), .carry(byte_cy)
  );

  // Next-state selection
  always_comb begin
    if (byte_sel) begin
      result_nxt = byte_sum;
      flags_nxt  = byte_cy;
      upd_flags  = 1'b1;
    end else begin
      result_nxt = {hi_res, lo_res};
      flags_nxt  = {{FPH{hi_nn}}, {FPH{lo_nn}}};
      upd_flags  = ~sat_sel;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      flags   <= '0;
      flag_we <= 1'b0;
    end else begin
      flag_we <= op_en & upd_flags;
      if (op_en) begin
        result <= result_nxt;
      end
      if (op_en && upd_flags) begin
        flags <= flags_nxt;
      end
    end
  end
endmodule

// File: rtl/pk_addsub_chk.sv
module pk_addsub_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_en,
  input logic [1:0]          op_sel,
  input logic                sat_sel,
  input logic                byte_sel,
  input logic [DATA_W-1:0]   result,
  input logic [DATA_W/8-1:0] flags,
  input logic                flag_we
);
  // R1: reset values
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert ((result == '0) && (flags == '0) && !flag_we)
        else $error("reset state wrong");
    end
  end

  // R10: strobe only follows a flag-writing issue
  assert_we_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> $past(op_en && (byte_sel || !sat_sel)))
    else $error("flag_we without wrapping op");

  // R10: result holds between issues
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_en) |-> $stable(result))
    else $error("result moved without op_en");

  // R11: flags move only with the strobe
  assert_flags_with_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags) |-> flag_we)
    else $error("flags changed without flag_we");

  // R8: saturating op writes no flags
  assert_sat_no_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_en && sat_sel && !byte_sel) |-> (!flag_we && $stable(flags)))
    else $error("saturating op touched flags");

  // R6: halfword flags come in equal pairs
  assert_pair_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !$past(byte_sel)) |-> ((flags[1] == flags[0]) && (flags[3] == flags[2])))
    else $error("halfword flag pair split");

  wire unused_ok = &{1'b0, op_sel};
endmodule

bind pk_addsub pk_addsub_chk #(.DATA_W(DATA_W)) i_pk_addsub_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel), .sat_sel(sat_sel),
  .byte_sel(byte_sel), .result(result), .flags(flags), .flag_we(flag_we)
);

// File: tb/test_pk_addsub.sv
module test_pk_addsub;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_en;
  logic [31:0] n_opd, m_opd;
  logic [1:0]  op_sel;
  logic        sat_sel, byte_sel;
  logic [31:0] result;
  logic [3:0]  flags;
  logic        flag_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [3:0]  exp_flags;   // bench's own copy of the flag state

  always #(CLK_PERIOD/2) clk = ~clk;

  pk_addsub i_pk_addsub (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .n_opd(n_opd), .m_opd(m_opd),
    .op_sel(op_sel), .sat_sel(sat_sel), .byte_sel(byte_sel),
    .result(result), .flags(flags), .flag_we(flag_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic signed [16:0] sx(input logic [15:0] v);
    return {v[15], v};
  endfunction

  function automatic logic [15:0] clamp(input logic signed [16:0] v);
    if (v > 17'sd32767)  return 16'h7FFF;
    if (v < -17'sd32768) return 16'h8000;
    return v[15:0];
  endfunction

  // Issue one operation, then compare against the model
  task automatic run_op(input string req, input logic [31:0] n, input logic [31:0] m,
                        input logic [1:0] op, input logic sat, input logic byt);
    logic signed [16:0] lo, hi;
    logic [31:0] exp_res;
    logic        exp_we;
    logic [8:0]  bs;
    if (byt) begin
      for (int k = 0; k < 4; k++) begin
        bs = {1'b0, n[8*k +: 8]} + {1'b0, m[8*k +: 8]};
        exp_res[8*k +: 8] = bs[7:0];
        exp_flags[k] = bs[8];
      end
      exp_we = 1'b1;
    end else begin
      case (op)
        2'd0: begin lo = sx(n[15:0]) + sx(m[15:0]);  hi = sx(n[31:16]) + sx(m[31:16]); end
        2'd1: begin lo = sx(n[15:0]) - sx(m[15:0]);  hi = sx(n[31:16]) - sx(m[31:16]); end
        2'd2: begin lo = sx(n[15:0]) + sx(m[31:16]); hi = sx(n[31:16]) - sx(m[15:0]);  end
        default: begin lo = sx(n[15:0]) - sx(m[31:16]); hi = sx(n[31:16]) + sx(m[15:0]); end
      endcase
      if (sat) begin
        exp_res = {clamp(hi), clamp(lo)};
        exp_we  = 1'b0;
      end else begin
        exp_res   = {hi[15:0], lo[15:0]};
        exp_flags = {{2{~hi[16]}}, {2{~lo[16]}}};
        exp_we    = 1'b1;
      end
    end
    @(negedge clk);
    n_opd = n; m_opd = m; op_sel = op; sat_sel = sat; byte_sel = byt; op_en = 1'b1;
    @(negedge clk);
    op_en = 1'b0;
    check({req, " result"}, result, exp_res);
    check({req, " flags"}, {28'd0, flags}, {28'd0, exp_flags});
    check({req, " flag_we"}, {31'd0, flag_we}, {31'd0, exp_we});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; op_en = 1'b0; n_opd = '0; m_opd = '0;
    op_sel = '0; sat_sel = 1'b0; byte_sel = 1'b0; exp_flags = '0;
    repeat (3) @(negedge clk);
    check("R1 result", result, 32'h0);
    check("R1 flags", {28'd0, flags}, 32'h0);
    check("R1 flag_we", {31'd0, flag_we}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_add;
    run_op("R2 mixed signs", 32'h0003_0005, 32'h0002_FFFA, 2'd0, 1'b0, 1'b0);
    run_op("R6 add past max", 32'h7FFF_7FFF, 32'h0001_0001, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_sub;
    run_op("R3 R11 below min", 32'h8000_0000, 32'h0001_0001, 2'd1, 1'b0, 1'b0);
    run_op("R3 plain", 32'h1234_0100, 32'h0034_0001, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_exchange;
    run_op("R4 xas", 32'h0100_0020, 32'h0003_0400, 2'd2, 1'b0, 1'b0);
    run_op("R5 xsa", 32'h0100_0020, 32'h0400_0003, 2'd3, 1'b0, 1'b0);
  endtask

  task automatic t_sat;
    run_op("R6 set all", 32'h0001_0001, 32'h0001_0001, 2'd0, 1'b0, 1'b0);
    run_op("R7 R8 sat hi", 32'h7FFF_7FF0, 32'h0001_0100, 2'd0, 1'b1, 1'b0);
    run_op("R7 R8 sat lo", 32'h8000_8005, 32'h0001_0010, 2'd1, 1'b1, 1'b0);
    run_op("R7 xsa sat", 32'h7FFF_8000, 32'h0001_0001, 2'd3, 1'b1, 1'b0);
  endtask

  task automatic t_bytes;
    run_op("R9 carries", 32'hFF80_0102, 32'h0180_01FF, 2'd3, 1'b1, 1'b1);
    run_op("R9 R11 no carry", 32'h0102_0304, 32'h1010_1010, 2'd1, 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    logic [31:0] r0;
    logic [3:0]  f0;
    run_op("R10 issue", 32'h0000_0005, 32'h0000_0003, 2'd1, 1'b0, 1'b0);
    r0 = result; f0 = flags;
    @(negedge clk);
    n_opd = 32'hDEAD_BEEF; m_opd = 32'h1234_5678; op_sel = 2'd2;
    repeat (2) @(negedge clk);
    check("R10 strobe drops", {31'd0, flag_we}, 32'h0);
    check("R10 result held", result, r0);
    check("R10 flags held", {28'd0, flags}, {28'd0, f0});
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_exchange();
    t_sat();
    t_bytes();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule